// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block collects the event sources inside a 16550-style UART and turns them into one 4-bit identity code and one interrupt request line. Each source is held as a pending flag that is set by its own event and cleared by its own condition. Register read and write strobes from the register file arrive as single-cycle pulses. The six sources are receive line error, receive data available, character timeout, transmit holding empty, modem line change and busy-write detect.

The highest-priority source that is both pending and enabled selects the identity code. If none qualifies, the code is 0001 and the request line is low. The block includes a character-timeout detector. It counts idle character-time ticks while the receive FIFO holds data.

The transmit-empty source has two modes. In the programmable threshold mode it compares the TX FIFO level against a threshold. Otherwise it follows a holding-register-empty flag.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset all pending flags are clear, `irq_id` is 4'b0001 and `irq` is low.
- R2: The identity codes are: line error 4'b0110, RX data 4'b0100, char timeout 4'b1100, TX empty 4'b0010, modem 4'b0000, busy 4'b0111, none 4'b0001. Priority runs from highest to lowest as line error, RX data, char timeout, TX empty, modem, busy. No other code ever appears.
- R3: An `ovr_err`, `par_err`, `frm_err` or `brk_det` pulse sets the line-error source. An `lsr_rd` pulse clears it. When a new error and `lsr_rd` fall in the same cycle, the source stays set.
- R4: With `fifo_en` low, an `rx_push` pulse sets RX data and an `rbr_rd` pulse clears it. When both fall in the same cycle, RX data stays set.
- R5: With `fifo_en` high, RX data is pending exactly one cycle after `rx_level >= rx_trig` holds. It clears one cycle after the level drops below the trigger.
- R6: With `fifo_en` high and `rx_level` nonzero, character timeout becomes pending after 4 `char_tick` pulses with no `rx_push` or `rbr_rd` in between. Any push or read restarts the count and clears the timeout.
- R7: When RX data and character timeout are pending together, 4'b0100 is reported.
- R8: With `fifo_en` and `thre_mode` both high, TX empty is set when `tx_level <= tx_thresh` becomes true, and `thr_empty` is ignored. Otherwise it is set when `thr_empty` becomes true.
- R9: TX empty clears on `iir_rd` only in a cycle where 4'b0010 is the reported code. It also clears when its condition becomes false, for example after a write fills the holding register or FIFO.
- R10: A change on any of `cts`, `dsr`, `ri`, `dcd` sets the modem source. An `msr_rd` pulse clears it. A change in the same cycle as `msr_rd` keeps it set.
- R11: `lcr_wr` while `uart_busy` is high sets busy detect. `lcr_wr` while not busy does nothing. `usr_rd` clears it.
- R12: The `src_en` bits are: bit0 line error, bit1 RX data and char timeout, bit2 TX empty, bit3 modem, bit4 busy. A masked source keeps its pending flag but is not reported. `irq` is high exactly when `irq_id` is not 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 5 | Per-source enables (see R12) |
| fifo_en | input | 1 | FIFOs enabled |
| thre_mode | input | 1 | Programmable TX threshold mode |
| ovr_err | input | 1 | Overrun error pulse |
| par_err | input | 1 | Parity error pulse |
| frm_err | input | 1 | Framing error pulse |
| brk_det | input | 1 | Break detected pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | LVL_W | RX FIFO occupancy |
| rx_trig | input | LVL_W | RX trigger level |
| rx_push | input | 1 | Character written into RX buffer/FIFO |
| rbr_rd | input | 1 | Receive buffer read strobe (FIFO pop) |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Holding register empty |
| tx_level | input | LVL_W | TX FIFO occupancy |
| tx_thresh | input | LVL_W | TX empty threshold |
| iir_rd | input | 1 | Identity register read strobe |
| cts | input | 1 | Clear-to-send line |
| dsr | input | 1 | Data-set-ready line |
| ri | input | 1 | Ring indicator line |
| dcd | input | 1 | Carrier detect line |
| msr_rd | input | 1 | Modem status read strobe |
| lcr_wr | input | 1 | Line control write strobe |
| uart_busy | input | 1 | UART busy |
| usr_rd | input | 1 | UART status read strobe |
| irq_id | output | 4 | Identity code |
| irq | output | 1 | Interrupt request |

## Verification
The sensitive collisions are a source's set event and its clear strobe in the same cycle. Cases include a new parity error with `lsr_rd`, a received character with `rbr_rd`, and a modem line change with `msr_rd`. The bench drives both pulses on the same clock edge and expects the source to remain reported, because a fresh event must not be lost.

A second collision involves `iir_rd` when TX empty is pending but hidden behind a higher source. The bench checks that this read leaves TX empty pending, and that TX empty appears once the higher source is cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM = 4'b0000,
    ID_NONE  = 4'b0001,
    ID_TXE   = 4'b0010,
    ID_RXD   = 4'b0100,
    ID_LINE  = 4'b0110,
    ID_BUSY  = 4'b0111,
    ID_CTO   = 4'b1100
  } irq_id_e;

  // Source index order is priority order: index 0 is highest.
  localparam int S_LINE = 0;
  localparam int S_RXD  = 1;
  localparam int S_CTO  = 2;
  localparam int S_TXE  = 3;
  localparam int S_MDM  = 4;
  localparam int S_BUSY = 5;
  localparam int NSRC   = 6;

  localparam int EN_LINE = 0;
  localparam int EN_RX   = 1;
  localparam int EN_TX   = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_BUSY = 4;
  localparam int NEN     = 5;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      S_LINE:  return ID_LINE;
      S_RXD:   return ID_RXD;
      S_CTO:   return ID_CTO;
      S_TXE:   return ID_TXE;
      S_MDM:   return ID_MODEM;
      S_BUSY:  return ID_BUSY;
      default: return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rx_timeout_det.sv
module rx_timeout_det #(
  parameter int LVL_W = 5,
  parameter int TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             timeout
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          restart, cnt_en;

  always_comb begin
    restart = rx_push | rx_pop | ~fifo_en | (rx_level == '0);
    cnt_en  = char_tick & (cnt_q != LIM);
    cnt_d   = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timeout = (cnt_q == LIM);
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             thre_mode,
  input  logic             line_evt,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             thr_empty,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic             tx_ack,
  input  logic [3:0]       mdm_lines,
  input  logic             msr_rd,
  input  logic             busy_evt,
  input  logic             usr_rd,
  output logic             line_p,
  output logic             rxd_p,
  output logic             txe_p,
  output logic             mdm_p,
  output logic             busy_p
);
  logic       line_d, rxd_d, txe_d, mdm_d, busy_d;
  logic       txc_q, tx_cond;
  logic [3:0] lines_q;
  logic       mdm_chg;

  always_comb begin
    tx_cond = (fifo_en & thre_mode) ? (tx_level <= tx_thresh) : thr_empty;
    mdm_chg = |(mdm_lines ^ lines_q);
    line_d  = line_evt | (line_p & ~lsr_rd);
    if (fifo_en) rxd_d = (rx_level >= rx_trig);
    else         rxd_d = rx_push | (rxd_p & ~rbr_rd);
    txe_d   = (tx_cond & ~txc_q) | (txe_p & tx_cond & ~tx_ack);
    mdm_d   = mdm_chg | (mdm_p & ~msr_rd);
    busy_d  = busy_evt | (busy_p & ~usr_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p  <= 1'b0;
      rxd_p   <= 1'b0;
      txe_p   <= 1'b0;
      txc_q   <= 1'b0;
      mdm_p   <= 1'b0;
      lines_q <= '0;
      busy_p  <= 1'b0;
    end else begin
      line_p  <= line_d;
      rxd_p   <= rxd_d;
      txe_p   <= txe_d;
      txc_q   <= tx_cond;
      mdm_p   <= mdm_d;
      lines_q <= mdm_lines;
      busy_p  <= busy_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output irq_id_e         id,
  output logic            req
);
  always_comb begin
    id = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) id = src_code(i);
    end
    req = |act;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W     = 5,
  parameter int CTO_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       src_en,
  input  logic             fifo_en,
  input  logic             thre_mode,
  input  logic             ovr_err,
  input  logic             par_err,
  input  logic             frm_err,
  input  logic             brk_det,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             char_tick,
  input  logic             thr_empty,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic             iir_rd,
  input  logic             cts,
  input  logic             dsr,
  input  logic             ri,
  input  logic             dcd,
  input  logic             msr_rd,
  input  logic             lcr_wr,
  input  logic             uart_busy,
  input  logic             usr_rd,
  output logic [3:0]       irq_id,
  output logic             irq
);
  logic [NSRC-1:0] pend, en_vec, act;
  irq_id_e         id_e;
  logic            tx_ack;

  assign tx_ack = iir_rd & (id_e == ID_TXE);

  irq_src_flags #(.LVL_W(LVL_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .thre_mode (thre_mode),
    .line_evt  (ovr_err | par_err | frm_err | brk_det),
    .lsr_rd    (lsr_rd),
    .rx_level  (rx_level),
    .rx_trig   (rx_trig),
    .rx_push   (rx_push),
    .rbr_rd    (rbr_rd),
    .thr_empty (thr_empty),
    .tx_level  (tx_level),
    .tx_thresh (tx_thresh),
    .tx_ack    (tx_ack),
    .mdm_lines ({dcd, ri, dsr, cts}),
    .msr_rd    (msr_rd),
    .busy_evt  (lcr_wr & uart_busy),
    .usr_rd    (usr_rd),
    .line_p    (pend[S_LINE]),
    .rxd_p     (pend[S_RXD]),
    .txe_p     (pend[S_TXE]),
    .mdm_p     (pend[S_MDM]),
    .busy_p    (pend[S_BUSY])
  );

  rx_timeout_det #(.LVL_W(LVL_W), .TICKS(CTO_TICKS)) u_cto (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rx_pop    (rbr_rd),
    .char_tick (char_tick),
    .timeout   (pend[S_CTO])
  );

  always_comb begin
    en_vec[S_LINE] = src_en[EN_LINE];
    en_vec[S_RXD]  = src_en[EN_RX];
    en_vec[S_CTO]  = src_en[EN_RX];
    en_vec[S_TXE]  = src_en[EN_TX];
    en_vec[S_MDM]  = src_en[EN_MDM];
    en_vec[S_BUSY] = src_en[EN_BUSY];
    act = pend & en_vec;
  end

  irq_prio_enc u_enc (
    .act (act),
    .id  (id_e),
    .req (irq)
  );

  assign irq_id = id_e;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] src_en,
  input logic       ovr_err,
  input logic       par_err,
  input logic       frm_err,
  input logic       brk_det,
  input logic       lsr_rd,
  input logic       rx_push,
  input logic       rbr_rd,
  input logic       lcr_wr,
  input logic       uart_busy,
  input logic [3:0] irq_id,
  input logic       irq
);
  logic err_any;
  assign err_any = ovr_err | par_err | frm_err | brk_det;

  assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && src_en[0]) |=> (irq_id == 4'b0110));

  assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !err_any && src_en == 5'b00001) |=> (irq_id == 4'b0001));

  assert_cto_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rbr_rd) |=> (irq_id != 4'b1100));

  assert_busy_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr && uart_busy && src_en == 5'b10000) |=> (irq_id == 4'b0111));

  assert_req_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_id != 4'b0001));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b0111, 4'b1100});
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_en    (src_en),
  .ovr_err   (ovr_err),
  .par_err   (par_err),
  .frm_err   (frm_err),
  .brk_det   (brk_det),
  .lsr_rd    (lsr_rd),
  .rx_push   (rx_push),
  .rbr_rd    (rbr_rd),
  .lcr_wr    (lcr_wr),
  .uart_busy (uart_busy),
  .irq_id    (irq_id),
  .irq       (irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] src_en;
  logic fifo_en, thre_mode, ovr_err, par_err, frm_err, brk_det, lsr_rd;
  logic [LW-1:0] rx_level, rx_trig, tx_level, tx_thresh;
  logic rx_push, rbr_rd, char_tick, thr_empty, iir_rd;
  logic cts, dsr, ri, dcd, msr_rd, lcr_wr, uart_busy, usr_rd;
  logic [3:0] irq_id;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  task automatic chk(input string req, input logic [3:0] exp_id);
    checks++;
    if (irq_id !== exp_id || irq !== (exp_id != 4'b0001)) begin
      errors++;
      $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", req, irq_id, irq,
               exp_id, exp_id != 4'b0001);
    end
  endtask

  // apply currently driven inputs over one rising edge, then clear strobes
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {ovr_err, par_err, frm_err, brk_det, lsr_rd, rx_push, rbr_rd} = '0;
    {char_tick, iir_rd, msr_rd, lcr_wr, usr_rd} = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 4'b0001);
  endtask

  task automatic t_line();
    par_err = 1; step(); chk("R3 parity sets", 4'b0110);
    lsr_rd = 1;  step(); chk("R3 lsr read clears", 4'b0001);
    brk_det = 1; step(); chk("R3 break sets", 4'b0110);
    lsr_rd = 1; frm_err = 1; step(); chk("R3 set beats clear", 4'b0110);
    lsr_rd = 1;  step(); chk("R3 cleared", 4'b0001);
  endtask

  task automatic t_rx_single();
    fifo_en = 0;
    rx_push = 1; step(); chk("R4 push sets", 4'b0100);
    rx_push = 1; rbr_rd = 1; step(); chk("R4 push beats read", 4'b0100);
    rbr_rd = 1;  step(); chk("R4 read clears", 4'b0001);
  endtask

  task automatic t_prio();
    rx_push = 1; ovr_err = 1; lcr_wr = 1; uart_busy = 1; cts = 1; step();
    chk("R2 line highest", 4'b0110);
    lsr_rd = 1; step(); chk("R2 rx next", 4'b0100);
    rbr_rd = 1; step(); chk("R2 modem over busy", 4'b0000);
    msr_rd = 1; step(); chk("R2 busy lowest", 4'b0111);
    usr_rd = 1; uart_busy = 0; step(); chk("R11 usr read clears", 4'b0001);
  endtask

  task automatic t_mask();
    src_en = 5'b11110;
    par_err = 1; step(); chk("R12 masked line not reported", 4'b0001);
    src_en = 5'b11111; #1; chk("R12 pending kept while masked", 4'b0110);
    lsr_rd = 1; step(); chk("R12 cleared", 4'b0001);
  endtask

  task automatic t_fifo_rx();
    fifo_en = 1; rx_trig = 4; rx_level = 3; step();
    chk("R5 below trigger", 4'b0001);
    rx_level = 4; step(); chk("R5 at trigger", 4'b0100);
    rx_level = 3; step(); chk("R5 falls below", 4'b0001);
  endtask

  task automatic t_timeout();
    rx_level = 2; rx_push = 1; step();
    for (int i = 0; i < 3; i++) begin char_tick = 1; step(); end
    chk("R6 three ticks not yet", 4'b0001);
    char_tick = 1; step(); chk("R6 fourth tick fires", 4'b1100);
    char_tick = 1; step(); chk("R6 stays after more ticks", 4'b1100);
    rbr_rd = 1; rx_level = 1; step(); chk("R6 read clears", 4'b0001);
    for (int i = 0; i < 2; i++) begin char_tick = 1; step(); end
    rx_push = 1; rx_level = 2; step();
    for (int i = 0; i < 3; i++) begin char_tick = 1; step(); end
    chk("R6 push restarts count", 4'b0001);
    char_tick = 1; step(); chk("R6 fires after restart", 4'b1100);
    rx_level = 4; step(); chk("R7 rx data over timeout", 4'b0100);
    rx_level = 0; step(); chk("R6 empty fifo clears", 4'b0001);
  endtask

  task automatic t_tx();
    fifo_en = 0; thre_mode = 0;
    thr_empty = 1; step(); chk("R8 holding empty sets", 4'b0010);
    iir_rd = 1; step(); chk("R9 iir read clears", 4'b0001);
    thr_empty = 0; step();
    thr_empty = 1; step(); chk("R8 sets again", 4'b0010);
    thr_empty = 0; step(); chk("R9 write clears", 4'b0001);
    fifo_en = 1; thre_mode = 1; tx_thresh = 2; tx_level = 5; thr_empty = 1; step();
    chk("R8 thr_empty ignored in threshold mode", 4'b0001);
    tx_level = 2; step(); chk("R8 at threshold sets", 4'b0010);
    tx_level = 3; step(); chk("R9 above threshold clears", 4'b0001);
    tx_level = 1; step();
    frm_err = 1; step(); chk("R9 tx hidden by line", 4'b0110);
    iir_rd = 1; step();
    lsr_rd = 1; step(); chk("R9 iir read while hidden keeps tx", 4'b0010);
    iir_rd = 1; step(); chk("R9 cleared when reported", 4'b0001);
    thre_mode = 0; thr_empty = 0; fifo_en = 0; step();
  endtask

  task automatic t_modem();
    dsr = 1; step(); chk("R10 dsr change", 4'b0000);
    msr_rd = 1; step(); chk("R10 msr read clears", 4'b0001);
    ri = 1; step(); chk("R10 ri change", 4'b0000);
    msr_rd = 1; dcd = 1; step(); chk("R10 change beats read", 4'b0000);
    msr_rd = 1; step(); chk("R10 cleared", 4'b0001);
  endtask

  task automatic t_busy();
    lcr_wr = 1; uart_busy = 0; step(); chk("R11 write while idle ignored", 4'b0001);
    lcr_wr = 1; uart_busy = 1; step(); chk("R11 write while busy", 4'b0111);
    usr_rd = 1; uart_busy = 0; step(); chk("R11 usr read clears", 4'b0001);
  endtask

  initial begin
    rst_n = 0; src_en = 5'b11111; fifo_en = 0; thre_mode = 0;
    {ovr_err, par_err, frm_err, brk_det, lsr_rd, rx_push, rbr_rd} = '0;
    {char_tick, iir_rd, msr_rd, lcr_wr, usr_rd, uart_busy} = '0;
    {cts, dsr, ri, dcd} = '0;
    thr_empty = 0; rx_level = 0; rx_trig = 1; tx_level = 0; tx_thresh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_line();
    t_rx_single();
    t_prio();
    t_mask();
    t_fifo_rx();
    t_timeout();
    t_tx();
    t_modem();
    t_busy();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule